// File: doc/BRIEF.md
# Iterative 512-bit AES-like Permutation Engine

This block computes one of two fixed 512-bit permutations built from AES-style round steps. The 512-bit operand is treated as an 8 by 8 matrix of bytes. A one-cycle start pulse loads the operand and latches a mode bit that selects the first permutation (mode 0) or the second (mode 1). The engine then computes one full round per clock, ten rounds in all, and pulses done for one cycle when the result is ready on the output.

Each round applies four steps in a fixed order. First a round-dependent constant is XORed into the state. Then every byte goes through the AES S-box. Each row is then rotated left by a row-dependent byte count. Finally each column is multiplied by a fixed circulant matrix over GF(2^8). The two permutations share this datapath. They differ only in where the constant goes, in an all-ones mask on every byte in mode 1, and in the rotation counts.

Top module: `grp_perm_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0 and state_o is all zeros.
- R2: A start pulse sampled while idle loads the operand. Exactly ten rounds follow, one per clock. done_o is high for exactly one cycle, on the tenth clock edge after the loading edge, and busy_o falls on that same edge.
- R3: In mode 0, the round constant for round i (0 to 9) is XORed into row 0 only. Column j receives the byte whose high nibble is j and whose low nibble is i.
- R4: In mode 1, every byte is XORed with 0xff in every round. In row 7, column j instead receives a total XOR whose high nibble is the complement of j and whose low nibble is the complement of i.
- R5: After the constant step, every byte is replaced by its AES S-box value: the GF(2^8) inverse (0 maps to 0), followed by the AES affine map with constant 0x63.
- R6: Row r is rotated left by s[r] byte positions, so that new[r][c] = old[r][(c+s[r]) mod 8]. The table s is {0,1,2,3,4,5,6,7} in mode 0 and {1,3,5,7,0,2,4,6} in mode 1.
- R7: Each column b is replaced by M·b over GF(2^8), reduced by x^8+x^4+x^3+x+1. M is circulant with M[r][k] = v[(k−r) mod 8] and v = (02,02,03,04,05,03,05,07).
- R8: A start pulse that arrives while busy_o is high is ignored. Neither the result nor the timing of done_o changes.
- R9: The mode bit is latched at start. Changing mode_i during a run does not affect the result.
- R10: Byte k of state_i and state_o (bits 8k+7 down to 8k) is matrix row k mod 8, column k div 8.
- R11: While idle and without a start pulse, state_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load operand and begin, taken only when idle |
| mode_i | input | 1 | 0 selects the first permutation, 1 the second |
| state_i | input | 512 | Operand, column-major bytes |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| state_o | output | 512 | Result, column-major bytes |

## Verification
An all-zero operand in each mode isolates the constant steps. With zero input, any misplaced constant row, wrong nibble order or missing 0xff mask shows up directly in the result. A single nonzero byte walked across the corners and edges of the matrix exposes errors in byte mapping, in the direction of each row's rotation and in the orientation of the column matrix. Pseudo-random operands in both modes exercise the S-box and GF multiplication across many byte values. Runs in which the mode flips mid-run, or a second start arrives while busy, must give the same result and done timing as a clean run.

// File: rtl/grp_pkg.sv
package grp_pkg;

    localparam int ROWS    = 8;
    localparam int COLS    = 8;
    localparam int BYTES   = ROWS * COLS;
    localparam int STATE_W = BYTES * 8;
    localparam int ROUNDS  = 10;
    localparam int RND_W   = $clog2(ROUNDS);

    typedef logic [7:0] byte_t;

    // GF(2^8) product, reduction polynomial x^8+x^4+x^3+x+1
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    // left-rotation amount of a row for either permutation
    function automatic int row_shift(input int q, input int r);
        if (q == 0) return r % COLS;
        return (2 * r + ((r < 4) ? 1 : 0)) % COLS;
    endfunction

    // first row of the circulant column-mixing matrix
    function automatic byte_t mix_coef(input int d);
        case (d % ROWS)
            0:       return 8'h02;
            1:       return 8'h02;
            2:       return 8'h03;
            3:       return 8'h04;
            4:       return 8'h05;
            5:       return 8'h03;
            6:       return 8'h05;
            default: return 8'h07;
        endcase
    endfunction

endpackage

// File: rtl/grp_sbox.sv
module grp_sbox
    import grp_pkg::*;
(
    input  logic [7:0] in_i,
    output logic [7:0] out_o
);
    byte_t x2, x3, x6, x12, x15, x30, x60, x120, x240, x252, inv;

    // inverse as x^254 through an addition chain
    always_comb begin
        x2   = gf_mul(in_i, in_i);
        x3   = gf_mul(x2, in_i);
        x6   = gf_mul(x3, x3);
        x12  = gf_mul(x6, x6);
        x15  = gf_mul(x12, x3);
        x30  = gf_mul(x15, x15);
        x60  = gf_mul(x30, x30);
        x120 = gf_mul(x60, x60);
        x240 = gf_mul(x120, x120);
        x252 = gf_mul(x240, x12);
        inv  = gf_mul(x252, x2);
        out_o = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
endmodule

// File: rtl/grp_round.sv
module grp_round
    import grp_pkg::*;
(
    input  logic [STATE_W-1:0] state_i,
    input  logic [RND_W-1:0]   rnd_i,
    input  logic               qsel_i,
    output logic [STATE_W-1:0] state_o
);
    byte_t ac_m [ROWS][COLS];
    byte_t sb_m [ROWS][COLS];
    byte_t sh_m [ROWS][COLS];

    logic [3:0] rnd4;
    assign rnd4 = 4'(rnd_i);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int K  = c * ROWS + r;
            localparam int SP = (c + row_shift(0, r)) % COLS;
            localparam int SQ = (c + row_shift(1, r)) % COLS;
            localparam logic [3:0] CN = 4'(c);

            // constant step
            always_comb begin
                byte_t k_d;
                k_d = 8'h00;
                if (!qsel_i) begin
                    if (r == 0) k_d = {CN, rnd4};
                end else begin
                    k_d = (r == ROWS - 1) ? {~CN, ~rnd4} : 8'hff;
                end
                ac_m[r][c] = state_i[8*K +: 8] ^ k_d;
            end

            grp_sbox u_sbox (
                .in_i  (ac_m[r][c]),
                .out_o (sb_m[r][c])
            );

            // row rotation
            assign sh_m[r][c] = qsel_i ? sb_m[r][SQ] : sb_m[r][SP];

            // column mixing
            always_comb begin
                byte_t acc_d;
                acc_d = 8'h00;
                for (int k = 0; k < ROWS; k++)
                    acc_d = acc_d ^ gf_mul(sh_m[k][c], mix_coef((k - r + ROWS) % ROWS));
                state_o[8*K +: 8] = acc_d;
            end
        end
    end
endmodule

// File: rtl/grp_perm_engine.sv
module grp_perm_engine
    import grp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               mode_i,
    input  logic [STATE_W-1:0] state_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [STATE_W-1:0] state_o
);
    typedef struct packed {
        logic               busy;
        logic               done;
        logic               qsel;
        logic [RND_W-1:0]   rnd;
        logic [STATE_W-1:0] st;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [STATE_W-1:0] round_out;

    grp_round u_round (
        .state_i (eng_q.st),
        .rnd_i   (eng_q.rnd),
        .qsel_i  (eng_q.qsel),
        .state_o (round_out)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (!eng_q.busy) begin
            if (start_i) begin
                eng_d.busy = 1'b1;
                eng_d.rnd  = '0;
                eng_d.qsel = mode_i;
                eng_d.st   = state_i;
            end
        end else begin
            eng_d.st = round_out;
            if (eng_q.rnd == RND_W'(ROUNDS - 1)) begin
                eng_d.busy = 1'b0;
                eng_d.done = 1'b1;
                eng_d.rnd  = '0;
            end else begin
                eng_d.rnd = eng_q.rnd + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy_o  = eng_q.busy;
    assign done_o  = eng_q.done;
    assign state_o = eng_q.st;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && eng_q.rnd == '0 && !done_o));
    assert_round_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && eng_q.rnd != RND_W'(ROUNDS - 1)) |=>
            (busy_o && eng_q.rnd == $past(eng_q.rnd) + 1'b1));
    assert_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && eng_q.rnd == RND_W'(ROUNDS - 1)) |=> (done_o && !busy_o));
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_mode_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(eng_q.qsel));
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(state_o));
endmodule

// File: tb/grp_perm_engine_test.sv
module grp_perm_engine_test;
    localparam int W = 512;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         mode_i = 1'b0;
    logic [W-1:0] state_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] state_o;

    int checks = 0;
    int failures = 0;
    logic [7:0] sbox_t [256];
    logic [63:0] seed = 64'h0123_4567_89ab_cdef;

    always #10 clk = ~clk;

    grp_perm_engine uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .state_i(state_i), .busy_o(busy_o), .done_o(done_o), .state_o(state_o)
    );

    function automatic logic [7:0] xt(input logic [7:0] v);
        return (v << 1) ^ (v[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] t = b;
        for (int i = 0; i < 8; i++) begin
            if (a[i]) p ^= t;
            t = xt(t);
        end
        return p;
    endfunction

    function automatic void build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            logic [7:0] s;
            for (int y = 1; y < 256; y++)
                if (x != 0 && mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
            sbox_t[x] = s ^ 8'h63;
        end
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] s, input bit q);
        logic [7:0] m [8][8];
        logic [7:0] t [8][8];
        int sig_p [8] = '{0,1,2,3,4,5,6,7};
        int sig_q [8] = '{1,3,5,7,0,2,4,6};
        logic [7:0] v [8] = '{8'h02,8'h02,8'h03,8'h04,8'h05,8'h03,8'h05,8'h07};
        logic [W-1:0] o;
        for (int k = 0; k < 64; k++) m[k%8][k/8] = s[8*k +: 8];
        for (int i = 0; i < 10; i++) begin
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++) begin
                    logic [7:0] b = m[r][c];
                    if (!q && r == 0) b ^= {4'(c), 4'(i)};
                    if (q) b ^= (r == 7) ? {4'(15 - c), 4'(15 - i)} : 8'hff;
                    t[r][c] = sbox_t[b];
                end
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++)
                    m[r][c] = t[r][(c + (q ? sig_q[r] : sig_p[r])) % 8];
            for (int c = 0; c < 8; c++)
                for (int r = 0; r < 8; r++) begin
                    logic [7:0] a = 0;
                    for (int k = 0; k < 8; k++) a ^= mul(v[(k - r + 8) % 8], m[k][c]);
                    t[r][c] = a;
                end
            m = t;
        end
        for (int k = 0; k < 64; k++) o[8*k +: 8] = m[k%8][k/8];
        return o;
    endfunction

    function automatic logic [W-1:0] rnd_state();
        logic [W-1:0] r;
        for (int w = 0; w < 8; w++) begin
            seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
            r[64*w +: 64] = seed;
        end
        return r;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // disturb: 0 none, 1 flip mode mid-run, 2 second start while busy
    task automatic run(input string req, input logic [W-1:0] st, input bit q, input int disturb);
        logic [W-1:0] exp = model(st, q);
        @(negedge clk);
        start_i = 1'b1; mode_i = q; state_i = st;
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (n == 1) start_i = 1'b0;
            if (disturb == 1 && n == 2) mode_i = ~q;
            if (disturb == 2 && n == 3) begin start_i = 1'b1; state_i = ~st; mode_i = ~q; end
            if (disturb == 2 && n == 4) start_i = 1'b0;
            if (n == 10) check_bit({req, " R2 done not early"}, done_o, 1'b0);
        end
        @(negedge clk);
        check_bit({req, " R2 done"}, done_o, 1'b1);
        check_bit({req, " R2 busy low"}, busy_o, 1'b0);
        check_vec(req, state_o, exp);
        @(negedge clk);
        check_bit({req, " R2 done one cycle"}, done_o, 1'b0);
        check_vec({req, " R11 hold"}, state_o, exp);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        build_sbox();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 busy", busy_o, 1'b0);
        check_bit("R1 done", done_o, 1'b0);
        check_vec("R1 state", state_o, '0);

        run("R3 zero mode0", '0, 1'b0, 0);
        run("R4 zero mode1", '0, 1'b1, 0);
        run("R4 ones mode1", '1, 1'b1, 0);
        run("R3 ones mode0", '1, 1'b0, 0);
        for (int k = 0; k < 64; k += 9) begin
            logic [W-1:0] s = '0;
            s[8*k +: 8] = 8'h5a;
            run("R10 R6 single byte mode0", s, 1'b0, 0);
            run("R10 R6 single byte mode1", s, 1'b1, 0);
        end
        begin
            logic [W-1:0] s;
            for (int k = 0; k < 64; k++) s[8*k +: 8] = 8'(k * 3 + 1);
            run("R7 counter mode0", s, 1'b0, 0);
            run("R7 counter mode1", s, 1'b1, 0);
        end
        for (int i = 0; i < 10; i++) begin
            run("R5 R7 random mode0", rnd_state(), 1'b0, 0);
            run("R5 R7 random mode1", rnd_state(), 1'b1, 0);
        end
        run("R9 mode flip mode0", rnd_state(), 1'b0, 1);
        run("R9 mode flip mode1", rnd_state(), 1'b1, 1);
        run("R8 start while busy mode0", rnd_state(), 1'b0, 2);
        run("R8 start while busy mode1", rnd_state(), 1'b1, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule